// File: doc/BRIEF.md
# Dual-Select DDR Memory Bus Master

This block is the host end of a narrow double-data-rate memory bus that serves two devices: a flash die and a self-refreshing DRAM die. Both share one 8-bit data bus, one bidirectional strobe and one clock. Each device has its own active-low select. A local port takes one 16-bit word per request, read or write. The top address bit chooses the device. The block then runs the full bus transaction and answers with a one-cycle response pulse.

The bus clock runs at half the system clock, so every system cycle carries exactly one bus clock edge and one byte. A transaction goes through five phases:

- select, with one cycle of clock-low setup;
- six command-address bytes;
- an initial latency, which the device may ask to double through the strobe level seen during the command phase;
- two data edges;
- a clock-low hold before the select rises.

Read bytes are taken on strobe transitions. On DRAM writes the strobe carries a per-byte mask.

Top module: `ddr_dual_master`

## Requirements
- R1: After a request is accepted, the chosen select falls with the clock low for one cycle. Then 6 command-address bytes follow, one per clock edge (the first edge is rising), most significant byte first. The word has: bit 47 = 1 for read, bit 46 = request register-space flag, bit 45 = 1 (linear burst, by parameter), bits 44:16 = address bits [ADDR_W-2:3] zero-extended, bits 15:3 = 0, bits 2:0 = address bits [2:0].
- R2: Address bit ADDR_W-1 = 0 selects the flash through `bus_cs_n[0]`; 1 selects the DRAM through `bus_cs_n[1]`. The two selects are never low together.
- R3: The strobe is sampled during the sixth command byte. If it reads 0, the first data edge comes after 2*LATENCY edges (LATENCY clocks). If it reads 1, it comes after 4*LATENCY edges.
- R4: Write data leaves on two consecutive edges, high byte `req_wdata[15:8]` first.
- R5: On DRAM writes the strobe is driven during the data edges with `~req_be` for that byte, where 1 means the byte is not written and `req_be[1]` covers the high byte. On flash writes the strobe is never driven, so all bytes are written.
- R6: On reads each strobe transition in the data phase captures one byte: first into `rsp_rdata[15:8]`, second into `rsp_rdata[7:0]`.
- R7: After the last data edge the clock stays low for HOLD_CYC cycles with the select still low. Then the select rises and `rsp_valid` pulses for exactly one cycle.
- R8: While no select is low, the clock is low and neither data nor strobe is driven. `req_ready` is high only in that idle state.
- R9: While `dev_reset_n` is low, from the next cycle on, both selects are high, no driver is enabled, `req_ready` is low and any open transaction is dropped without a response.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, twice the bus clock rate |
| rst_n | input | 1 | Active-low reset of the block |
| dev_reset_n | input | 1 | Active-low hardware reset of the memory devices |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_reg | input | 1 | Register-space access flag |
| req_addr | input | ADDR_W | Word address; top bit picks the device |
| req_wdata | input | 8*WORD_BYTES | Write word |
| req_be | input | WORD_BYTES | Byte enables, 1 = write the byte |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8*WORD_BYTES | Read word |
| bus_ck | output | 1 | Bus clock |
| bus_cs_n | output | 2 | Selects: bit 0 flash, bit 1 DRAM |
| bus_dq_o | output | 8 | Data bus out |
| bus_dq_oe | output | 1 | Data bus drive enable |
| bus_dq_i | input | 8 | Data bus in |
| bus_rwds_o | output | 1 | Strobe out (write mask) |
| bus_rwds_oe | output | 1 | Strobe drive enable |
| bus_rwds_i | input | 1 | Strobe in (latency flag, read strobe) |

## Verification
The bound checker watches, on every cycle, the properties that do not depend on data:
- the two selects are never low together;
- the idle bus is quiet and ready appears only when idle;
- the flash never sees a driven strobe;
- the clock-low hold comes before each select release;
- the response is a single pulse;
- the bus is released under device reset.

Only the bench's responder and scoreboard can show the rest: the command bytes and their order, the doubled latency (through the exact edge on which data is exchanged), byte masking and read-back values. The abandoned transaction under device reset is also shown this way, with the latency flag chosen per transaction both at random and forced.

// File: rtl/mbus_pkg.sv
package mbus_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SEL,
      ST_CA,
      ST_LAT,
      ST_WR,
      ST_RD,
      ST_HOLD
   } mbus_state_e;

   localparam int CA_BYTES = 6;
   localparam int CA_W     = 8 * CA_BYTES;
   localparam int UPPER_W  = 29;
   localparam int GAP_W    = 13;
endpackage

// File: rtl/mbus_ca_build.sv
module mbus_ca_build
   import mbus_pkg::*;
#(
   parameter int ADDR_W       = 24,
   parameter bit LINEAR_BURST = 1'b1
) (
   input  logic              rd,
   input  logic              reg_space,
   input  logic [ADDR_W-2:0] addr,
   output logic [CA_W-1:0]   ca
);
   localparam int UP_W = ADDR_W - 4;

   if (UP_W < 1 || UP_W > UPPER_W) begin : g_bad_addr_w
      $error("mbus_ca_build: ADDR_W must lie in 5..33");
   end

   logic [UPPER_W-1:0] upper;

   always_comb begin
      upper            = '0;
      upper[UP_W-1:0]  = addr[ADDR_W-2:3];
      ca               = {rd, reg_space, LINEAR_BURST, upper, {GAP_W{1'b0}}, addr[2:0]};
   end
endmodule

// File: rtl/mbus_lat_timer.sv
module mbus_lat_timer #(
   parameter int LATENCY = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic dbl_in,
   input  logic run,
   output logic last
);
   localparam int SINGLE_EDGES = 2 * LATENCY;
   localparam int DOUBLE_EDGES = 4 * LATENCY;
   localparam int CNT_W        = $clog2(DOUBLE_EDGES + 1);

   logic [CNT_W-1:0] cnt;
   logic             dbl;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         dbl <= 1'b0;
      end else if (load) begin
         cnt <= '0;
         dbl <= dbl_in;
      end else if (run) begin
         cnt <= cnt + CNT_W'(1);
      end
   end

   assign last = run && (cnt == (dbl ? CNT_W'(DOUBLE_EDGES - 1) : CNT_W'(SINGLE_EDGES - 1)));
endmodule

// File: rtl/mbus_strobe_capture.sv
module mbus_strobe_capture #(
   parameter int LANES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clear,
   input  logic               en,
   input  logic               strobe,
   input  logic [7:0]         din,
   output logic [8*LANES-1:0] word,
   output logic               done
);
   localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1;

   logic             strobe_q;
   logic [IDX_W-1:0] idx;
   logic             hit;

   assign hit  = en && (strobe != strobe_q);
   assign done = hit && (idx == IDX_W'(LANES - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         strobe_q <= 1'b0;
         idx      <= '0;
      end else begin
         strobe_q <= strobe;
         if (clear)    idx <= '0;
         else if (hit) idx <= idx + IDX_W'(1);
      end
   end

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [7:0] lane_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                         lane_q <= '0;
         else if (hit && idx == IDX_W'(l))   lane_q <= din;
      end
      assign word[8*(LANES-1-l) +: 8] = lane_q;
   end
endmodule

// File: rtl/ddr_dual_master.sv
module ddr_dual_master
   import mbus_pkg::*;
#(
   parameter int ADDR_W       = 24,
   parameter int WORD_BYTES   = 2,
   parameter int LATENCY      = 6,
   parameter int HOLD_CYC     = 2,
   parameter bit LINEAR_BURST = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    dev_reset_n,
   input  logic                    req_valid,
   output logic                    req_ready,
   input  logic                    req_write,
   input  logic                    req_reg,
   input  logic [ADDR_W-1:0]       req_addr,
   input  logic [8*WORD_BYTES-1:0] req_wdata,
   input  logic [WORD_BYTES-1:0]   req_be,
   output logic                    rsp_valid,
   output logic [8*WORD_BYTES-1:0] rsp_rdata,
   output logic                    bus_ck,
   output logic [1:0]              bus_cs_n,
   output logic [7:0]              bus_dq_o,
   output logic                    bus_dq_oe,
   input  logic [7:0]              bus_dq_i,
   output logic                    bus_rwds_o,
   output logic                    bus_rwds_oe,
   input  logic                    bus_rwds_i
);
   localparam int DW      = 8 * WORD_BYTES;
   localparam int MAX_AB  = (CA_BYTES > WORD_BYTES) ? CA_BYTES : WORD_BYTES;
   localparam int SEQ_MAX = (MAX_AB > HOLD_CYC) ? MAX_AB : HOLD_CYC;
   localparam int SEQ_W   = $clog2(SEQ_MAX + 1);

   if (LATENCY < 2 || LATENCY > 16) begin : g_bad_latency
      $error("ddr_dual_master: LATENCY must lie in 2..16");
   end
   if (HOLD_CYC < 2) begin : g_bad_hold
      $error("ddr_dual_master: HOLD_CYC must cover one bus clock (>= 2)");
   end
   if (WORD_BYTES < 1 || WORD_BYTES > 8) begin : g_bad_word
      $error("ddr_dual_master: WORD_BYTES must lie in 1..8");
   end

   mbus_state_e       st;
   logic [SEQ_W-1:0]  seq;
   logic              ck_q;
   logic [1:0]        cs_q;
   logic [CA_W-1:0]   ca_q;
   logic              wr_q;
   logic              tgt_q;
   logic [DW-1:0]     wdata_q;
   logic [WORD_BYTES-1:0] be_q;
   logic              rsp_q;

   logic [CA_W-1:0]   ca_new;
   logic              accept;
   logic              ca_last, wr_last, hold_last;
   logic              lat_last, cap_done;
   logic [DW-1:0]     cap_word;

   assign req_ready = (st == ST_IDLE) && dev_reset_n;
   assign accept    = req_valid && req_ready;
   assign ca_last   = (st == ST_CA)   && (seq == SEQ_W'(CA_BYTES - 1));
   assign wr_last   = (st == ST_WR)   && (seq == SEQ_W'(WORD_BYTES - 1));
   assign hold_last = (st == ST_HOLD) && (seq == SEQ_W'(HOLD_CYC - 1));

   mbus_ca_build #(
      .ADDR_W       (ADDR_W),
      .LINEAR_BURST (LINEAR_BURST)
   ) i_ca_build (
      .rd        (!req_write),
      .reg_space (req_reg),
      .addr      (req_addr[ADDR_W-2:0]),
      .ca        (ca_new)
   );

   mbus_lat_timer #(
      .LATENCY (LATENCY)
   ) i_lat_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (ca_last),
      .dbl_in (bus_rwds_i),
      .run    (st == ST_LAT),
      .last   (lat_last)
   );

   mbus_strobe_capture #(
      .LANES (WORD_BYTES)
   ) i_capture (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (accept),
      .en     (st == ST_RD),
      .strobe (bus_rwds_i),
      .din    (bus_dq_i),
      .word   (cap_word),
      .done   (cap_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         seq     <= '0;
         ck_q    <= 1'b0;
         cs_q    <= 2'b11;
         ca_q    <= '0;
         wr_q    <= 1'b0;
         tgt_q   <= 1'b0;
         wdata_q <= '0;
         be_q    <= '0;
         rsp_q   <= 1'b0;
      end else if (!dev_reset_n) begin
         st    <= ST_IDLE;
         seq   <= '0;
         ck_q  <= 1'b0;
         cs_q  <= 2'b11;
         rsp_q <= 1'b0;
      end else begin
         rsp_q <= 1'b0;
         unique case (st)
            ST_IDLE: begin
               if (accept) begin
                  st      <= ST_SEL;
                  ca_q    <= ca_new;
                  wr_q    <= req_write;
                  tgt_q   <= req_addr[ADDR_W-1];
                  wdata_q <= req_wdata;
                  be_q    <= req_be;
                  cs_q    <= req_addr[ADDR_W-1] ? 2'b01 : 2'b10;
               end
            end
            ST_SEL: begin
               st   <= ST_CA;
               seq  <= '0;
               ck_q <= 1'b1;
            end
            ST_CA: begin
               ck_q <= ~ck_q;
               if (ca_last) begin
                  st  <= ST_LAT;
                  seq <= '0;
               end else begin
                  seq <= seq + SEQ_W'(1);
               end
            end
            ST_LAT: begin
               ck_q <= ~ck_q;
               if (lat_last) begin
                  st  <= wr_q ? ST_WR : ST_RD;
                  seq <= '0;
               end
            end
            ST_WR: begin
               if (wr_last) begin
                  st   <= ST_HOLD;
                  seq  <= '0;
                  ck_q <= 1'b0;
               end else begin
                  seq  <= seq + SEQ_W'(1);
                  ck_q <= ~ck_q;
               end
            end
            ST_RD: begin
               if (cap_done) begin
                  st   <= ST_HOLD;
                  seq  <= '0;
                  ck_q <= 1'b0;
               end else begin
                  ck_q <= ~ck_q;
               end
            end
            ST_HOLD: begin
               if (hold_last) begin
                  st    <= ST_IDLE;
                  seq   <= '0;
                  cs_q  <= 2'b11;
                  rsp_q <= 1'b1;
               end else begin
                  seq <= seq + SEQ_W'(1);
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   logic [CA_W-1:0]       ca_sh;
   logic [DW-1:0]         wd_sh;
   logic [WORD_BYTES-1:0] be_sh;

   always_comb begin
      ca_sh = ca_q << (8 * seq);
      wd_sh = wdata_q << (8 * seq);
      be_sh = be_q << seq;
      unique case (st)
         ST_CA:   bus_dq_o = ca_sh[CA_W-1 -: 8];
         ST_WR:   bus_dq_o = wd_sh[DW-1 -: 8];
         default: bus_dq_o = 8'h00;
      endcase
   end

   assign bus_dq_oe   = (st == ST_CA) || (st == ST_WR);
   assign bus_rwds_oe = (st == ST_WR) && tgt_q;
   assign bus_rwds_o  = bus_rwds_oe && !be_sh[WORD_BYTES-1];
   assign bus_ck      = ck_q;
   assign bus_cs_n    = cs_q;
   assign rsp_valid   = rsp_q;
   assign rsp_rdata   = cap_word;
endmodule

// File: rtl/ddr_dual_master_chk.sv
module ddr_dual_master_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       dev_reset_n,
   input logic       req_ready,
   input logic       rsp_valid,
   input logic       bus_ck,
   input logic [1:0] bus_cs_n,
   input logic       bus_dq_oe,
   input logic       bus_rwds_oe
);
   // R2: never both devices selected
   p_one_select_r2: assert property (@(posedge clk) disable iff (!rst_n)
      bus_cs_n != 2'b00);

   // R8: idle bus is quiet
   p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_cs_n == 2'b11) |-> (!bus_ck && !bus_dq_oe && !bus_rwds_oe));

   // R8: ready only while no device is selected
   p_ready_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (bus_cs_n == 2'b11));

   // R5: the flash never receives a driven strobe
   p_flash_no_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_cs_n[0] |-> !bus_rwds_oe);

   // R5: a mask only travels with write data
   p_mask_with_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rwds_oe |-> bus_dq_oe);

   // R7: select release preceded by clock-low hold
   p_hold_before_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(&bus_cs_n) && $past(dev_reset_n)) |-> ($past(!bus_ck) && $past(!bus_ck, 2) && $past(!bus_dq_oe)));

   // R7: response is a single pulse
   p_rsp_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   // R7: response coincides with select release
   p_rsp_at_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> ((bus_cs_n == 2'b11) && $past(bus_cs_n != 2'b11)));

   // R9: device reset releases the bus and drops the response
   p_reset_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !dev_reset_n |=> ((bus_cs_n == 2'b11) && !bus_dq_oe && !bus_rwds_oe && !rsp_valid));
endmodule

bind ddr_dual_master ddr_dual_master_chk i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .dev_reset_n (dev_reset_n),
   .req_ready   (req_ready),
   .rsp_valid   (rsp_valid),
   .bus_ck      (bus_ck),
   .bus_cs_n    (bus_cs_n),
   .bus_dq_oe   (bus_dq_oe),
   .bus_rwds_oe (bus_rwds_oe)
);

// File: tb/test_ddr_dual_master.sv
module test_ddr_dual_master;
   localparam int LAT = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        dev_reset_n = 1'b1;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_write = 1'b0;
   logic        req_reg = 1'b0;
   logic [23:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic [1:0]  req_be = '0;
   logic        rsp_valid;
   logic [15:0] rsp_rdata;
   logic        bus_ck;
   logic [1:0]  bus_cs_n;
   logic [7:0]  bus_dq_o;
   logic        bus_dq_oe;
   logic [7:0]  bus_dq_i = '0;
   logic        bus_rwds_o;
   logic        bus_rwds_oe;
   logic        bus_rwds_i = 1'b0;

   always #10 clk = ~clk;

   ddr_dual_master i_ddr_dual_master (
      .clk(clk), .rst_n(rst_n), .dev_reset_n(dev_reset_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_reg(req_reg), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .bus_ck(bus_ck), .bus_cs_n(bus_cs_n), .bus_dq_o(bus_dq_o), .bus_dq_oe(bus_dq_oe),
      .bus_dq_i(bus_dq_i), .bus_rwds_o(bus_rwds_o), .bus_rwds_oe(bus_rwds_oe),
      .bus_rwds_i(bus_rwds_i)
   );

   typedef struct packed {
      logic        rd;
      logic        tgt;
      logic [47:0] ca;
      logic [15:0] rdata;
   } exp_t;

   exp_t        exp_q[$];
   logic [15:0] ref_mem [int];
   logic [15:0] dev_mem [int];
   int          n_checks = 0;
   int          n_errors = 0;
   bit          finished = 1'b0;
   int          xmode = -1;
   bit          abort_pending = 1'b0;

   task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic finish_sim();
      if (!finished) begin
         finished = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   endtask

   function automatic logic [15:0] default_word(input int key);
      return key[15:0] ^ (key[23] ? 16'hC3A5 : 16'h5A3C);
   endfunction

   function automatic logic [15:0] ref_read(input int key);
      if (ref_mem.exists(key)) return ref_mem[key];
      return default_word(key);
   endfunction

   function automatic logic [15:0] dev_read(input int key);
      if (dev_mem.exists(key)) return dev_mem[key];
      return default_word(key);
   endfunction

   // driver: issues one request and pushes the expected outcome
   task automatic do_req(input bit wr, input bit rg, input logic [23:0] a,
                         input logic [15:0] d, input logic [1:0] be, input bit track);
      exp_t        e;
      int          key;
      logic [15:0] old;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1;
      req_write = wr;
      req_reg   = rg;
      req_addr  = a;
      req_wdata = d;
      req_be    = be;
      key       = int'(a);
      e.rd      = !wr;
      e.tgt     = a[23];
      e.ca      = {~wr, rg, 1'b1, 9'd0, a[22:3], 13'd0, a[2:0]};
      e.rdata   = 16'h0;
      if (wr) begin
         old = ref_read(key);
         if (!a[23]) ref_mem[key] = d;
         else ref_mem[key] = {be[1] ? d[15:8] : old[15:8], be[0] ? d[7:0] : old[7:0]};
      end else begin
         e.rdata = ref_read(key);
      end
      if (track) exp_q.push_back(e);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   // behavioural responder for both devices
   bit          active = 1'b0;
   int          edge_n = 0;
   int          dedge = 0;
   int          low_cnt = 0;
   logic        prev_ck = 1'b0;
   logic        extra = 1'b0;
   logic        r_tgt = 1'b0;
   logic [47:0] ca_acc = '0;
   logic [47:0] last_ca = '0;
   logic        last_tgt = 1'b0;
   bit          check_idle = 1'b0;

   always @(negedge clk) begin
      if (!rst_n) begin
         active     = 1'b0;
         bus_rwds_i = 1'b0;
         bus_dq_i   = 8'h00;
      end else begin
         if (check_idle) begin
            check_idle = 1'b0;
            check(!bus_ck && !bus_dq_oe && !bus_rwds_oe, "R8 bus quiet after release",
                  {bus_ck, bus_dq_oe, bus_rwds_oe}, 0);
         end
         if (bus_cs_n != 2'b11 && !active) begin
            active     = 1'b1;
            edge_n     = 0;
            low_cnt    = 0;
            prev_ck    = bus_ck;
            r_tgt      = !bus_cs_n[1];
            extra      = (xmode < 0) ? 1'($urandom % 2) : 1'(xmode);
            dedge      = 6 + 2 * LAT * (extra ? 2 : 1);
            bus_rwds_i = extra;
         end else if (bus_cs_n == 2'b11 && active) begin
            active     = 1'b0;
            bus_rwds_i = 1'b0;
            bus_dq_i   = 8'h00;
            if (abort_pending) begin
               abort_pending = 1'b0;
            end else begin
               check(edge_n == dedge + 2, "R3 edge count per transaction", edge_n, dedge + 2);
               check(low_cnt >= 2, "R7 clock-low hold before release", low_cnt, 2);
               check_idle = 1'b1;
            end
         end
         if (active && bus_ck != prev_ck) begin
            low_cnt = 0;
            if (edge_n < 6) begin
               check(bus_dq_oe, "R1 command byte driven", bus_dq_oe, 1);
               ca_acc = {ca_acc[39:0], bus_dq_o};
            end else begin
               int          key;
               logic [15:0] w;
               if (edge_n == 6) begin
                  bus_rwds_i = 1'b0;
                  last_ca    = ca_acc;
                  last_tgt   = r_tgt;
               end
               key = int'({r_tgt, ca_acc[35:16], ca_acc[2:0]});
               if (edge_n == dedge || edge_n == dedge + 1) begin
                  w = dev_read(key);
                  if (ca_acc[47]) begin
                     bus_dq_i   = (edge_n == dedge) ? w[15:8] : w[7:0];
                     bus_rwds_i = (edge_n == dedge);
                  end else begin
                     check(bus_dq_oe, "R4 write byte driven on data edge", bus_dq_oe, 1);
                     if (!r_tgt)
                        check(!bus_rwds_oe, "R5 flash write leaves strobe undriven", bus_rwds_oe, 0);
                     if (!(r_tgt && bus_rwds_oe && bus_rwds_o)) begin
                        if (edge_n == dedge) w[15:8] = bus_dq_o;
                        else w[7:0] = bus_dq_o;
                        dev_mem[key] = w;
                     end
                  end
               end
            end
            edge_n++;
         end else if (active && !bus_ck) begin
            low_cnt++;
         end
         prev_ck = bus_ck;
      end
   end

   // monitor: pops expected items as responses appear
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R9 response with no open request", 1, 0);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            check(last_ca == e.ca, "R1 command-address word", last_ca, e.ca);
            check(last_tgt == e.tgt, "R2 device select", last_tgt, e.tgt);
            if (e.rd) check(rsp_rdata == e.rdata, "R6 read data", rsp_rdata, e.rdata);
         end
      end
   end

   // watchdog
   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000) begin
         check(1'b0, "watchdog expired", cyc, 0);
         finish_sim();
      end
   end

   task automatic drain();
      int n = 0;
      while ((exp_q.size() != 0 || !req_ready) && n < 2000) begin
         @(negedge clk);
         n++;
      end
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(req_ready == 1'b1, "R8 ready after reset", req_ready, 1);
      check(bus_cs_n == 2'b11, "R8 no select after reset", bus_cs_n, 2'b11);
      check(!bus_ck, "R8 clock low after reset", bus_ck, 0);
      check(!bus_dq_oe && !bus_rwds_oe, "R8 no drivers after reset", {bus_dq_oe, bus_rwds_oe}, 0);
      check(!rsp_valid, "R7 no response after reset", rsp_valid, 0);

      // R4: plain DRAM write and read-back, no extra latency
      xmode = 0;
      do_req(1, 0, 24'h800013, 16'h1234, 2'b11, 1);
      do_req(0, 0, 24'h800013, 16'h0, 2'b00, 1);
      // R3: forced extra latency, flash ignores mask (R5)
      xmode = 1;
      do_req(1, 0, 24'h000025, 16'hBEEF, 2'b00, 1);
      do_req(0, 0, 24'h000025, 16'h0, 2'b00, 1);
      // R5: DRAM masks
      do_req(1, 0, 24'h800013, 16'hAAAA, 2'b10, 1);
      do_req(0, 0, 24'h800013, 16'h0, 2'b00, 1);
      xmode = 0;
      do_req(1, 0, 24'h800013, 16'h5555, 2'b01, 1);
      do_req(1, 0, 24'h800013, 16'hFFFF, 2'b00, 1);
      do_req(0, 0, 24'h800013, 16'h0, 2'b00, 1);
      // R1: register space flag, untouched word, wide address
      do_req(0, 1, 24'h7FFFF9, 16'h0, 2'b00, 1);
      do_req(0, 1, 24'hABCDEF, 16'h0, 2'b00, 1);
      drain();

      // random mix with random latency flag
      xmode = -1;
      for (int i = 0; i < 40; i++) begin
         logic [23:0] a;
         a = {1'($urandom % 2), 15'd0, 8'($urandom % 32)};
         do_req(1'($urandom % 2), 1'b0, a, 16'($urandom), 2'($urandom), 1);
      end
      drain();

      // R9: device reset in the middle of a read
      xmode = 0;
      abort_pending = 1'b1;
      do_req(0, 0, 24'h800002, 16'h0, 2'b00, 0);
      repeat (10) @(negedge clk);
      dev_reset_n = 1'b0;
      @(negedge clk);
      check(bus_cs_n == 2'b11, "R9 selects released in device reset", bus_cs_n, 2'b11);
      check(!bus_dq_oe && !bus_rwds_oe, "R9 drivers released in device reset", {bus_dq_oe, bus_rwds_oe}, 0);
      check(!req_ready, "R9 not ready in device reset", req_ready, 0);
      repeat (3) @(negedge clk);
      dev_reset_n = 1'b1;
      @(negedge clk);
      check(req_ready, "R9 ready after device reset", req_ready, 1);
      repeat (60) @(negedge clk);

      // operation resumes
      do_req(0, 0, 24'h800013, 16'h0, 2'b00, 1);
      do_req(1, 0, 24'h000007, 16'hC0DE, 2'b11, 1);
      do_req(0, 0, 24'h000007, 16'h0, 2'b00, 1);
      drain();
      check(exp_q.size() == 0, "R7 every request answered", exp_q.size(), 0);
      finish_sim();
   end
endmodule